// File: doc/BRIEF.md
# Deferred-Fault Speculative Load Tracker

This block keeps the bookkeeping that lets a load run ahead of the branch that guards it. When a speculative load issues, its destination register is marked as holding an outstanding speculative value. If the memory system later reports a fault for that load, the fault is not raised. Instead a poison token is parked on the destination register. A later check operation on the register consumes that state. A clean register passes. A poisoned register produces a one-cycle recovery request that carries the register index. A check that finds no outstanding speculative load for its register raises an error flag.

A normal, non-speculative register write removes any outstanding speculation and any poison on that register. The tracker holds one pending bit and one poison bit for each architectural register. The check result is returned on registered outputs in the cycle after the check is presented. Every check reads the register's state as it stood before the updates of its own cycle.

Top module: `spec_ld_tracker`

## Requirements
- R1: After reset no register is pending: all outputs are 0, and a check on any register reports an error.
- R2: A check on a register with a pending, unpoisoned speculative load asserts `chk_pass` in the following cycle only.
- R3: A check on a pending, poisoned register asserts `recov_req` for exactly the following cycle, with `recov_reg` equal to the checked index.
- R4: A check on a register with no pending speculative load asserts `chk_err` in the following cycle, with neither `chk_pass` nor `recov_req`.
- R5: A non-speculative write clears both the pending bit and the poison bit of its register, so a later check on that register reports an error.
- R6: A passing check clears the pending bit, so a second check on the same register reports an error.
- R7: A failing check consumes the register's state: pending and poison are cleared, so a second check reports an error.
- R8: A fault report for a register with no pending speculative load is ignored: a later check reports an error, not a recovery.
- R9: A speculative load issued in the same cycle as a fault report for the same register wins: the register ends pending and unpoisoned.
- R10: A speculative load issued in the same cycle as a non-speculative write to the same register wins: the register ends pending.
- R11: Each check produces exactly one of `chk_pass`, `recov_req` or `chk_err` in the next cycle. A cycle without a check produces none of them in the next cycle.
- R12: A check sees the register state from before its own cycle. A load to the checked register in that cycle does not affect the result, and neither does a fault in that cycle. The check's consumption is applied after a fault in the same cycle, so both pending and poison end cleared.
- R13: `recov_reg` is 0 in every cycle where `recov_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Speculative load issued this cycle |
| ld_reg | input | IDX_W (5) | Destination register of the speculative load |
| flt_valid | input | 1 | Memory reports a fault for a speculative load |
| flt_reg | input | IDX_W (5) | Destination register of the faulting load |
| wr_valid | input | 1 | Non-speculative register write |
| wr_reg | input | IDX_W (5) | Register written |
| chk_valid | input | 1 | Check operation issued |
| chk_reg | input | IDX_W (5) | Register being checked |
| chk_pass | output | 1 | Previous cycle's check succeeded |
| recov_req | output | 1 | Previous cycle's check found a deferred fault |
| recov_reg | output | IDX_W (5) | Register needing recovery, 0 when idle |
| chk_err | output | 1 | Previous cycle's check had no matching speculative load |

## Verification
A pending bit that is stuck or lost shows up as a wrong result type on the very next check of that register. A stray 1 turns an error into a pass or recovery, and a stray 0 does the reverse. That result appears one cycle after the check. A poison bit that is set, kept or cleared wrongly swaps pass and recovery on that same next-cycle output. Wrong same-cycle precedence among load, write, fault and check only appears on the check that follows the collision. The bench therefore forces collisions on a small register subset and compares every cycle against a behavioural model.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

   typedef enum logic [1:0] {
      CHK_NONE  = 2'd0,
      CHK_PASS  = 2'd1,
      CHK_RECOV = 2'd2,
      CHK_ERR   = 2'd3
   } chk_res_e;

   function automatic chk_res_e classify(input logic valid,
                                         input logic pend,
                                         input logic pois);
      chk_res_e r;
      if (!valid)     r = CHK_NONE;
      else if (!pend) r = CHK_ERR;
      else if (pois)  r = CHK_RECOV;
      else            r = CHK_PASS;
      return r;
   endfunction

endpackage

// File: rtl/spec_trk_onehot.sv
module spec_trk_onehot #(
   parameter int N = 32,
   parameter int W = 5
) (
   input  logic         en,
   input  logic [W-1:0] idx,
   output logic [N-1:0] hot
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      assign hot[g] = en && (idx == W'(g));
   end
endmodule

// File: rtl/spec_trk_cell.sv
module spec_trk_cell #(
   parameter bit CLEAR_ON_FAIL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_hit,
   input  logic wr_hit,
   input  logic flt_hit,
   input  logic chk_hit,
   output logic pend,
   output logic pois
);
   logic pend_nx, pois_nx;
   logic pois_after_chk;

   if (CLEAR_ON_FAIL) begin : g_clr
      assign pois_after_chk = 1'b0;
   end else begin : g_keep
      assign pois_after_chk = pois;
   end

   always_comb begin
      pend_nx = pend;
      pois_nx = pois;
      if (flt_hit && pend) pois_nx = 1'b1;
      if (chk_hit) begin
         pend_nx = 1'b0;
         pois_nx = pois_after_chk;
      end
      if (wr_hit) begin
         pend_nx = 1'b0;
         pois_nx = 1'b0;
      end
      if (ld_hit) begin
         pend_nx = 1'b1;
         pois_nx = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= 1'b0;
         pois <= 1'b0;
      end else begin
         pend <= pend_nx;
         pois <= pois_nx;
      end
   end
endmodule

// File: rtl/spec_trk_resp.sv
module spec_trk_resp
   import spec_trk_pkg::*;
#(
   parameter int N = 32,
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         chk_valid,
   input  logic [W-1:0] chk_reg,
   input  logic [N-1:0] pend_vec,
   input  logic [N-1:0] pois_vec,
   output logic         chk_pass,
   output logic         recov_req,
   output logic [W-1:0] recov_reg,
   output logic         chk_err
);
   chk_res_e res, res_q;
   logic [W-1:0] reg_q;

   assign res = classify(chk_valid, pend_vec[chk_reg], pois_vec[chk_reg]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= CHK_NONE;
         reg_q <= '0;
      end else begin
         res_q <= res;
         reg_q <= (res == CHK_RECOV) ? chk_reg : '0;
      end
   end

   assign chk_pass  = (res_q == CHK_PASS);
   assign recov_req = (res_q == CHK_RECOV);
   assign chk_err   = (res_q == CHK_ERR);
   assign recov_reg = reg_q;
endmodule

// File: rtl/spec_ld_tracker.sv
module spec_ld_tracker #(
   parameter int NUM_REGS      = 32,
   parameter bit CLEAR_ON_FAIL = 1'b1,
   parameter int IDX_W         = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_valid,
   input  logic [IDX_W-1:0] ld_reg,
   input  logic             flt_valid,
   input  logic [IDX_W-1:0] flt_reg,
   input  logic             wr_valid,
   input  logic [IDX_W-1:0] wr_reg,
   input  logic             chk_valid,
   input  logic [IDX_W-1:0] chk_reg,
   output logic             chk_pass,
   output logic             recov_req,
   output logic [IDX_W-1:0] recov_reg,
   output logic             chk_err
);
   if (NUM_REGS < 2) begin : g_bad_n
      $error("spec_ld_tracker: NUM_REGS must be at least 2");
   end
   if ((1 << IDX_W) < NUM_REGS) begin : g_bad_w
      $error("spec_ld_tracker: IDX_W too narrow for NUM_REGS");
   end

   logic [NUM_REGS-1:0] ld_hot, wr_hot, flt_hot, chk_hot;
   logic [NUM_REGS-1:0] pend_vec, pois_vec;

   spec_trk_onehot #(.N(NUM_REGS), .W(IDX_W)) u_dec_ld
      (.en(ld_valid),  .idx(ld_reg),  .hot(ld_hot));
   spec_trk_onehot #(.N(NUM_REGS), .W(IDX_W)) u_dec_wr
      (.en(wr_valid),  .idx(wr_reg),  .hot(wr_hot));
   spec_trk_onehot #(.N(NUM_REGS), .W(IDX_W)) u_dec_flt
      (.en(flt_valid), .idx(flt_reg), .hot(flt_hot));
   spec_trk_onehot #(.N(NUM_REGS), .W(IDX_W)) u_dec_chk
      (.en(chk_valid), .idx(chk_reg), .hot(chk_hot));

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_cell
      spec_trk_cell #(.CLEAR_ON_FAIL(CLEAR_ON_FAIL)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_hit (ld_hot[r]),
         .wr_hit (wr_hot[r]),
         .flt_hit(flt_hot[r]),
         .chk_hit(chk_hot[r]),
         .pend   (pend_vec[r]),
         .pois   (pois_vec[r])
      );
   end

   spec_trk_resp #(.N(NUM_REGS), .W(IDX_W)) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .chk_valid(chk_valid),
      .chk_reg  (chk_reg),
      .pend_vec (pend_vec),
      .pois_vec (pois_vec),
      .chk_pass (chk_pass),
      .recov_req(recov_req),
      .recov_reg(recov_reg),
      .chk_err  (chk_err)
   );
endmodule

// File: rtl/spec_ld_tracker_chk.sv
module spec_ld_tracker_chk #(
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_valid,
   input logic [IDX_W-1:0] ld_reg,
   input logic             chk_valid,
   input logic [IDX_W-1:0] chk_reg,
   input logic             chk_pass,
   input logic             recov_req,
   input logic [IDX_W-1:0] recov_reg,
   input logic             chk_err
);
   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   a_r11_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> $countones({chk_pass, recov_req, chk_err}) == 1);

   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !(chk_pass || recov_req || chk_err));

   a_r13_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
      !recov_req |-> recov_reg == '0);

   a_r3_index: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && recov_req) |-> recov_reg == $past(chk_reg));

   a_r6_no_double_consume: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && chk_valid && $past(chk_valid) && chk_reg == $past(chk_reg)
       && !($past(ld_valid) && $past(ld_reg) == chk_reg))
      |=> chk_err);
endmodule

bind spec_ld_tracker spec_ld_tracker_chk #(.IDX_W(IDX_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_valid (ld_valid),
   .ld_reg   (ld_reg),
   .chk_valid(chk_valid),
   .chk_reg  (chk_reg),
   .chk_pass (chk_pass),
   .recov_req(recov_req),
   .recov_reg(recov_reg),
   .chk_err  (chk_err)
);

// File: tb/sim_spec_ld_tracker.sv
module sim_spec_ld_tracker;
   localparam int N = 32;
   localparam int W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_valid = 0, flt_valid = 0, wr_valid = 0, chk_valid = 0;
   logic [W-1:0] ld_reg = 0, flt_reg = 0, wr_reg = 0, chk_reg = 0;
   logic chk_pass, recov_req, chk_err;
   logic [W-1:0] recov_reg;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   spec_ld_tracker u0 (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_reg(ld_reg),
      .flt_valid(flt_valid), .flt_reg(flt_reg),
      .wr_valid(wr_valid), .wr_reg(wr_reg),
      .chk_valid(chk_valid), .chk_reg(chk_reg),
      .chk_pass(chk_pass), .recov_req(recov_req),
      .recov_reg(recov_reg), .chk_err(chk_err)
   );

   bit m_pend [N];
   bit m_pois [N];
   bit e_pass, e_recov, e_err;
   int e_reg;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_pend[i]) begin m_pend[i] = 0; m_pois[i] = 0; end
         e_pass <= 0; e_recov <= 0; e_err <= 0; e_reg <= 0;
      end else begin
         bit p, q;
         p = 0; q = 0;
         e_pass <= 0; e_recov <= 0; e_err <= 0; e_reg <= 0;
         if (chk_valid) begin
            if (!m_pend[chk_reg]) q = 1;
            else if (m_pois[chk_reg]) p = 1;
            if (q) e_err <= 1;
            else if (p) begin e_recov <= 1; e_reg <= int'(chk_reg); end
            else e_pass <= 1;
         end
         if (flt_valid && m_pend[flt_reg]) m_pois[flt_reg] = 1;
         if (chk_valid) begin m_pend[chk_reg] = 0; m_pois[chk_reg] = 0; end
         if (wr_valid) begin m_pend[wr_reg] = 0; m_pois[wr_reg] = 0; end
         if (ld_valid) begin m_pend[ld_reg] = 1; m_pois[ld_reg] = 0; end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (chk_pass !== e_pass) begin
            failures++;
            $display("FAIL R2 model chk_pass act=%0b exp=%0b", chk_pass, e_pass);
         end
         if (recov_req !== e_recov) begin
            failures++;
            $display("FAIL R3 model recov_req act=%0b exp=%0b", recov_req, e_recov);
         end
         if (chk_err !== e_err) begin
            failures++;
            $display("FAIL R4 model chk_err act=%0b exp=%0b", chk_err, e_err);
         end
         if (int'(recov_reg) != e_reg) begin
            failures++;
            $display("FAIL R13 model recov_reg act=%0d exp=%0d", recov_reg, e_reg);
         end
      end
   end

   task automatic cyc(input bit l, input int lr, input bit f, input int fr,
                      input bit w, input int wrr, input bit c, input int cr);
      ld_valid = l;  ld_reg = W'(lr);
      flt_valid = f; flt_reg = W'(fr);
      wr_valid = w;  wr_reg = W'(wrr);
      chk_valid = c; chk_reg = W'(cr);
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic expect_out(input bit p, input bit rq, input bit e, input int rr,
                             input string tag);
      checks++;
      if (chk_pass !== p || recov_req !== rq || chk_err !== e || int'(recov_reg) != rr) begin
         failures++;
         $display("FAIL %s act pass=%0b recov=%0b err=%0b reg=%0d exp pass=%0b recov=%0b err=%0b reg=%0d",
                  tag, chk_pass, recov_req, chk_err, recov_reg, p, rq, e, rr);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      expect_out(0, 0, 0, 0, "R1 reset outputs");
      cyc(0,0, 0,0, 0,0, 1,7);  expect_out(0, 0, 1, 0, "R1 nothing pending");
      // R2 clean speculative load then check
      cyc(1,3, 0,0, 0,0, 0,0);
      idle();
      cyc(0,0, 0,0, 0,0, 1,3);  expect_out(1, 0, 0, 0, "R2 clean pass");
      // R6 second check after pass
      cyc(0,0, 0,0, 0,0, 1,3);  expect_out(0, 0, 1, 0, "R6 pending cleared");
      // R3 deferred fault
      cyc(1,4, 0,0, 0,0, 0,0);
      cyc(0,0, 1,4, 0,0, 0,0);
      cyc(0,0, 0,0, 0,0, 1,4);  expect_out(0, 1, 0, 4, "R3 recovery");
      idle();                   expect_out(0, 0, 0, 0, "R3 one cycle");
      // R7 after failed check
      cyc(0,0, 0,0, 0,0, 1,4);  expect_out(0, 0, 1, 0, "R7 state consumed");
      // R4 never loaded
      cyc(0,0, 0,0, 0,0, 1,9);  expect_out(0, 0, 1, 0, "R4 no load");
      // R5 write clears
      cyc(1,6, 0,0, 0,0, 0,0);
      cyc(0,0, 1,6, 0,0, 0,0);
      cyc(0,0, 0,0, 1,6, 0,0);
      cyc(0,0, 0,0, 0,0, 1,6);  expect_out(0, 0, 1, 0, "R5 write clears");
      // R8 fault without pending
      cyc(0,0, 1,10, 0,0, 0,0);
      cyc(0,0, 0,0, 0,0, 1,10); expect_out(0, 0, 1, 0, "R8 stray fault");
      // R9 load beats fault
      cyc(1,11, 0,0, 0,0, 0,0);
      cyc(1,11, 1,11, 0,0, 0,0);
      cyc(0,0, 0,0, 0,0, 1,11); expect_out(1, 0, 0, 0, "R9 load wins");
      // R10 load beats write
      cyc(1,12, 0,0, 1,12, 0,0);
      cyc(0,0, 0,0, 0,0, 1,12); expect_out(1, 0, 0, 0, "R10 load wins");
      // R12 check uses pre-cycle state
      cyc(1,13, 0,0, 0,0, 1,13); expect_out(0, 0, 1, 0, "R12 old state err");
      cyc(0,0, 0,0, 0,0, 1,13);  expect_out(1, 0, 0, 0, "R12 load landed");
      cyc(1,14, 0,0, 0,0, 0,0);
      cyc(0,0, 1,14, 0,0, 1,14); expect_out(1, 0, 0, 0, "R12 fault same cycle");
      cyc(0,0, 0,0, 0,0, 1,14);  expect_out(0, 0, 1, 0, "R12 consumed");
      // R11 quiet cycle
      idle();                    expect_out(0, 0, 0, 0, "R11 no check");
      // random collisions on a small subset, compared by the model each cycle
      for (int i = 0; i < 4000; i++) begin
         cyc(($urandom % 3) == 0, $urandom % 4,
             ($urandom % 3) == 0, $urandom % 4,
             ($urandom % 5) == 0, $urandom % 4,
             ($urandom % 2) == 0, $urandom % 4);
      end
      idle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule